// File: doc/BRIEF.md
# Crank Pulse Period Capture Timer

The block measures engine speed as a time interval. A low-resolution crank signal, four pulses per crankshaft revolution, enters through a two-flop synchronizer. Each rising edge closes one measurement. A free-running tick counter runs off a timebase built in two stages from the system clock. The first stage divides by `DIV_A` (4) and the second by `DIV_B` (48). From a 12.5829 MHz clock this gives close to 65536 ticks per second. At one pulse per second the crank turns at 15 RPM.

On every accepted edge the tick count since the previous edge is latched into a 16-bit period register. The counter and both prescale stages then restart, and a status flag is raised. Software reads the period and turns it into scaled speed values. It reads the status word at its own address to see which events are pending, and it writes ones to that same address to clear them. An interrupt line is high while any flag is pending.

Top module: `crank_period_timer`

## Requirements
- R1: After reset the period register reads 0, the status word reads 0 and `irq_o` is low.
- R2: With N = DIV_A*DIV_B clocks per tick and D clocks between two accepted rising edges, the period register becomes min(floor((D-1)/N), 2^CNT_W-1) on the second edge. It keeps that value until the next accepted edge.
- R3: One tick occurs every DIV_A*DIV_B system clocks, and both prescale stages restart on each accepted edge. As a result, gaps of k*N and k*N+1 clocks give periods of k-1 and k.
- R4: Address 0 reads the period, zero-extended to 16 bits. Address 1 reads the status word, with bit 10 = new period, bit 11 = counter stalled, bit 12 = period overrun and bit 13 = armed. Status bits outside mask 0x3C00 read 0, and addresses 2 and 3 read 0.
- R5: Only rising edges of `pulse_i`, seen after the two-flop synchronizer, are counted. A falling edge leaves the period and the status word unchanged.
- R6: Once the tick counter reaches 2^CNT_W-1 it holds there, and status bit 11 sets.
- R7: A write to address 1 clears exactly the status bits written as 1. A write to any other address changes nothing.
- R8: A flag that sets in the same cycle as a write that clears it stays set.
- R9: The first accepted edge after reset sets bit 13 and starts counting. It does not change the period and does not set bit 10.
- R10: An accepted edge that arrives while bit 10 is still pending sets bit 12.
- R11: `irq_o` is high exactly while the status word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Low-resolution crank pulse, asynchronous |
| reg_addr_i | input | 2 | Register address: 0 period, 1 status |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data (ones clear status bits) |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| irq_o | output | 1 | High while any status bit is set |

## Verification
Random gaps between edges are compared with the floor formula. Directed gaps at exact multiples of the tick length and one clock past them tell apart an off-by-one in the tick position or a prescaler that does not restart. A gap long enough to saturate the counter separates holding at the maximum from wrapping. Repeated edges with no clear in between show whether overrun is detected. A long high pulse shows whether falling edges are wrongly accepted. A clear that lands in the same cycle as a new capture decides whether a set wins over a clear.

// File: rtl/crank_pkg.sv
package crank_pkg;
  localparam int REG_W = 16;
  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  // status bit positions, fixed by the software view
  localparam int ST_CAPT = 10;
  localparam int ST_STALL = 11;
  localparam int ST_OVR = 12;
  localparam int ST_ARM = 13;
  localparam logic [REG_W-1:0] ST_MASK = 16'h3C00;

  typedef struct packed {
    logic arm;
    logic ovr;
    logic stall;
    logic capt;
  } st_flags_t;
endpackage

// File: rtl/crank_sync_edge.sv
module crank_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic rise_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pulse_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
endmodule

// File: rtl/crank_div_stage.sv
module crank_div_stage #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic strb_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic wrap;

  assign wrap   = (cnt_q == LAST);
  assign strb_o = en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/crank_prescaler.sv
module crank_prescaler #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int NSTG = 2;
  logic [NSTG:0] en;

  assign en[0] = 1'b1;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    crank_div_stage #(.DIV((g == 0) ? DIV_A : DIV_B)) u_stg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en[g]),
      .clr_i (clr_i),
      .strb_o(en[g+1])
    );
  end

  assign tick_o = en[NSTG];
endmodule

// File: rtl/crank_tick_counter.sv
module crank_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] period_o,
  output logic             armed_o,
  output logic             capt_o,
  output logic             stall_o,
  output logic             arm_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q, period_q;
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= '0;
      armed_q  <= 1'b0;
    end else if (rise_i) begin
      if (armed_q) period_q <= cnt_q;
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && tick_i && cnt_q != CMAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign period_o = period_q;
  assign armed_o  = armed_q;
  assign capt_o   = rise_i & armed_q;
  assign arm_o    = rise_i & ~armed_q;
  assign stall_o  = ~rise_i & armed_q & tick_i & (cnt_q == CMAX - 1'b1);
endmodule

// File: rtl/crank_status_reg.sv
module crank_status_reg
  import crank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capt_i,
  input  logic             stall_i,
  input  logic             arm_i,
  input  logic             clr_en_i,
  input  logic [REG_W-1:0] clr_data_i,
  output logic [REG_W-1:0] status_o
);
  st_flags_t flg_q, set_v, clr_v;

  always_comb begin
    set_v.capt  = capt_i;
    set_v.stall = stall_i;
    set_v.ovr   = capt_i & flg_q.capt;
    set_v.arm   = arm_i;
    clr_v.capt  = clr_en_i & clr_data_i[ST_CAPT];
    clr_v.stall = clr_en_i & clr_data_i[ST_STALL];
    clr_v.ovr   = clr_en_i & clr_data_i[ST_OVR];
    clr_v.arm   = clr_en_i & clr_data_i[ST_ARM];
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~clr_v) | set_v;
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_CAPT]  = flg_q.capt;
    status_o[ST_STALL] = flg_q.stall;
    status_o[ST_OVR]   = flg_q.ovr;
    status_o[ST_ARM]   = flg_q.arm;
  end
endmodule

// File: rtl/crank_period_timer.sv
module crank_period_timer
  import crank_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 48,
  parameter int CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pulse_i,
  input  logic [1:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o
);
  logic rise, tick, armed, capt, stall, arm;
  logic [CNT_W-1:0] cnt, period;
  logic [REG_W-1:0] status;

  crank_sync_edge u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse_i),
    .rise_o (rise)
  );

  crank_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rise),
    .tick_o(tick)
  );

  crank_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .rise_i  (rise),
    .cnt_o   (cnt),
    .period_o(period),
    .armed_o (armed),
    .capt_o  (capt),
    .stall_o (stall),
    .arm_o   (arm)
  );

  crank_status_reg u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capt_i    (capt),
    .stall_i   (stall),
    .arm_i     (arm),
    .clr_en_i  (reg_wr_i && reg_addr_i == ADDR_STATUS),
    .clr_data_i(reg_wdata_i),
    .status_o  (status)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_PERIOD: reg_rdata_o = REG_W'(period);
      ADDR_STATUS: reg_rdata_o = status;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |status;
endmodule

// File: rtl/crank_period_timer_chk.sv
module crank_period_timer_chk #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 48,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rise,
  input logic             tick,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic [15:0]      status
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam int TICK_N = DIV_A * DIV_B;

  a_r2_period_only_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(period));
  a_r9_first_edge_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !armed) |=> ($stable(period) && !status[10] && status[13]));
  a_r6_hold_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CMAX && !rise) |=> cnt == CMAX);
  a_r6_stall_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[11]) |-> cnt == CMAX);
  a_r4_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status & ~16'h3C00) == 16'h0);
  a_r8_capture_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && armed) |=> status[10]);
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TICK_N > 1 && tick) |=> !tick);
endmodule

bind crank_period_timer crank_period_timer_chk #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CNT_W(CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .rise  (rise),
  .tick  (tick),
  .armed (armed),
  .cnt   (cnt),
  .period(period),
  .status(status)
);

// File: tb/sim_crank_period_timer.sv
module sim_crank_period_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DA = 2;
  localparam int DB = 3;
  localparam int CW = 8;
  localparam int TN = DA * DB;
  localparam int PMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, pulse = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = 16'h0, rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crank_period_timer #(.DIV_A(DA), .DIV_B(DB), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic int exp_period(int d);
    int p = (d - 1) / TN;
    return (p > PMAX) ? PMAX : p;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wreg(logic [1:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = 16'h0;
  endtask

  // rising edge at start, high for hi cycles, next start gap cycles later
  task automatic pls(int gap, int hi = 2);
    pulse = 1'b1;
    repeat (hi) @(negedge clk);
    pulse = 1'b0;
    repeat (gap - hi) @(negedge clk);
  endtask

  task automatic measure(string req, int d);
    logic [15:0] v;
    wreg(2'd1, 16'hFFFF);
    pls(d);
    pls(6);
    rd(2'd0, v);
    chk(req, v, 16'(exp_period(d)));
    rd(2'd1, v);
    chk("R10 overrun after two edges", v & 16'h1400, 16'h1400);
  endtask

  initial begin
    int guard = 0;
    while (!done) begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R1 period at reset", v, 16'h0);
    rd(2'd1, v); chk("R1 status at reset", v, 16'h0);
    chk("R1 irq at reset", {15'h0, irq}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // first edge arms only
    pls(40);
    rd(2'd1, v); chk("R9 first edge sets armed only", v, 16'h2000);
    rd(2'd0, v); chk("R9 first edge no period", v, 16'h0);
    chk("R11 irq with pending flag", {15'h0, irq}, 16'h1);
    rd(2'd2, v); chk("R4 unused address reads zero", v, 16'h0);

    // writes elsewhere and reserved bits have no effect
    wreg(2'd0, 16'hFFFF);
    wreg(2'd1, 16'hC3FF);
    rd(2'd1, v); chk("R7 reserved or other-address write", v, 16'h2000);
    wreg(2'd1, 16'h2000);
    rd(2'd1, v); chk("R7 clear armed", v, 16'h0);
    chk("R11 irq low when clear", {15'h0, irq}, 16'h0);

    // directed gaps around tick boundaries
    measure("R3 gap 2N", 2 * TN);
    measure("R3 gap 2N+1", 2 * TN + 1);
    measure("R2 gap 10N", 10 * TN);
    measure("R2 gap 10N+1", 10 * TN + 1);
    // random gaps
    for (int i = 0; i < 10; i++) begin
      int d = 8 + int'($urandom % 1400);
      measure("R2 random gap", d);
    end

    // falling edge ignored: long high pulse
    wreg(2'd1, 16'hFFFF);
    pls(30 * TN, 20 * TN);
    rd(2'd1, v); chk("R5 after long pulse", v & 16'h3C00, 16'h0400);
    pls(6);
    rd(2'd0, v); chk("R5 falling edge not counted", v, 16'(exp_period(30 * TN)));

    // saturation
    wreg(2'd1, 16'hFFFF);
    pls(2);
    repeat ((PMAX + 5) * TN) @(negedge clk);
    rd(2'd1, v); chk("R6 stall flag", v & 16'h0800, 16'h0800);
    pls(6);
    rd(2'd0, v); chk("R6 saturated period", v, 16'(PMAX));
    wreg(2'd1, 16'h0400);
    rd(2'd1, v); chk("R7 clear only written bit", v & 16'h3C00, 16'h1800);

    // set beats clear in the same cycle
    wreg(2'd1, 16'hFFFF);
    pulse = 1'b1;
    @(negedge clk);
    @(negedge clk);
    pulse = 1'b0;
    addr = 2'd1; wdata = 16'h0400; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = 16'h0;
    repeat (4) @(negedge clk);
    rd(2'd1, v); chk("R8 set wins over clear", v & 16'h0400, 16'h0400);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule